// File: doc/BRIEF.md
# Proximity Card Command Interpreter

This block is the command interpreter of a type-A proximity card. A framing layer in front of it has already stripped parity and CRC and presents each received command as one frame: a command code, a parameter byte and a page address, qualified by a one-cycle valid strobe. For every frame the block updates the card's logical state. It then either answers with a response frame (answer-to-request, one half of the cascaded UID, or a negative acknowledge), or grants a memory or authentication action to the units behind it, or stays silent.

The UID responses are assembled from a stored 7-byte serial number, and the check byte of each cascade level is computed inside the block. The cipher engine reports a successful challenge exchange through a single-cycle strobe. A sticky flag records that a HALT has been executed since power-on. That flag decides whether an unexpected command sends the card back to the idle state or to the halt state.

Top module: `picc_cmd_ctrl`

## Requirements
- R1: After reset the card is in the idle state (`card_state` code 0), and no response, grant or authentication strobe is active.
- R2: Request code 26h is accepted only in idle, and wake-up code 52h only in idle or halt. Each answers with `rsp_kind` 1, `rsp_len` 2 and the two answer-to-request bytes (low byte 44h in bits 7:0, then 00h), and moves the card to ready-1 (code 1).
- R3: Cascade code 93h is honoured only in ready-1 and 95h only in ready-2 (code 2). A parameter byte of 70h marks a select, which moves ready-1 to ready-2 and ready-2 to active (code 3). Any other parameter value leaves the state unchanged.
- R4: A cascade answer has `rsp_kind` 2 and `rsp_len` 5, with the first byte in bits 7:0. Level 1 sends 88h, SN0, SN1, SN2 and then 88h^SN0^SN1^SN2. Level 2 sends SN3, SN4, SN5, SN6 and then SN3^SN4^SN5^SN6. SN0 is `uid_in[7:0]`.
- R5: A read (30h) of address 0 in ready-1 or ready-2 moves the card straight to active and raises the read grant. A read of any other address in those states counts as unexpected.
- R6: In active or authenticated (code 4), a read (30h), a write (A2h) or a compatibility write (A0h) whose address is at most 2Bh raises the matching one-cycle grant, with the frame address on `mem_addr`. A higher address gives a negative acknowledge (`rsp_kind` 3, `rsp_len` 1, data 0), and the state does not change.
- R7: HALT (50h) is accepted in ready-1, ready-2, active and authenticated. It moves the card silently to halt (code 5) and sets the sticky halted flag, which only reset clears.
- R8: An unknown code, or a code received in a state that does not accept it, gets no response. It moves the card to idle, or to halt if the halted flag is set.
- R9: Authentication step one (1Ah) is accepted in active or authenticated. Step two (AFh) is accepted only as the frame that directly follows an accepted step one. Both raise `auth_stb`. An `auth_ok` strobe after an accepted step two, with no frame in between, moves the card to authenticated. In every other situation `auth_ok` has no effect.
- R10: Responses and grants appear for exactly the one cycle after the frame's valid cycle, and each frame produces at most one of them.
- R11: With `ALLOW_CWRITE` set to 0, code A0h is treated as an unknown code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| frm_valid | input | 1 | One-cycle strobe qualifying a decoded frame |
| frm_cmd | input | 8 | Command code |
| frm_param | input | 8 | Parameter byte |
| frm_addr | input | ADDR_W | Page address |
| auth_ok | input | 1 | Successful authentication strobe from the cipher unit |
| uid_in | input | 8*UID_BYTES | Stored serial number, SN0 in the low byte |
| rsp_valid | output | 1 | Response frame present |
| rsp_kind | output | 2 | 1 answer-to-request, 2 UID part, 3 negative acknowledge |
| rsp_len | output | 3 | Response length in bytes |
| rsp_data | output | 40 | Response bytes, first byte in bits 7:0 |
| mem_rd_stb | output | 1 | Read grant |
| mem_wr_stb | output | 1 | Write grant |
| mem_addr | output | ADDR_W | Page address of the granted access |
| auth_stb | output | 1 | Authentication step grant |
| card_state | output | 3 | Current logical state code |

## Verification
The bench builds the block with an 8-bit address and a last page of 2Bh, so that the first address out of range, 2Ch, can be reached directly. It sweeps all 256 command codes, each with three parameter and address combinations, from every logical state and also from ready-1 after a halt. That sweep reaches every accept, reject and fall-back path against an arithmetic model of the state rules. A second instance built with compatibility writes disabled shows how that variant treats A0h.

// File: rtl/picc_pkg.sv
package picc_pkg;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_RDY1 = 3'd1,
      ST_RDY2 = 3'd2,
      ST_ACT  = 3'd3,
      ST_AUTH = 3'd4,
      ST_HALT = 3'd5
   } card_st_e;

   typedef enum logic [3:0] {
      K_REQ, K_WAKE, K_CL1, K_CL2, K_READ, K_WRITE,
      K_HALT, K_AU1, K_AU2, K_BAD
   } cmd_kind_e;

   typedef enum logic [1:0] {
      RK_NONE = 2'd0,
      RK_ATQA = 2'd1,
      RK_UID  = 2'd2,
      RK_NAK  = 2'd3
   } rsp_kind_e;

   localparam logic [7:0] OP_REQ    = 8'h26;
   localparam logic [7:0] OP_WAKE   = 8'h52;
   localparam logic [7:0] OP_CL1    = 8'h93;
   localparam logic [7:0] OP_CL2    = 8'h95;
   localparam logic [7:0] OP_READ   = 8'h30;
   localparam logic [7:0] OP_HALT   = 8'h50;
   localparam logic [7:0] OP_WRITE  = 8'hA2;
   localparam logic [7:0] OP_CWRITE = 8'hA0;
   localparam logic [7:0] OP_AU1    = 8'h1A;
   localparam logic [7:0] OP_AU2    = 8'hAF;

   localparam int RSP_BYTES = 5;

endpackage

// File: rtl/picc_cmd_decode.sv
module picc_cmd_decode
   import picc_pkg::*;
#(
   parameter int         ADDR_W       = 8,
   parameter int         LAST_PAGE    = 8'h2B,
   parameter logic [7:0] SEL_CODE     = 8'h70,
   parameter bit         ALLOW_CWRITE = 1'b1
) (
   input  logic [7:0]        cmd,
   input  logic [7:0]        param,
   input  logic [ADDR_W-1:0] addr,
   output cmd_kind_e         kind,
   output logic              sel,
   output logic              addr_ok,
   output logic              addr_zero
);

   localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(LAST_PAGE);

   generate
      if (ADDR_W < 1 || ADDR_W > 16) begin : g_bad_w
         $error("picc_cmd_decode: ADDR_W out of range");
      end
      if (LAST_PAGE < 0 || LAST_PAGE >= (1 << ADDR_W)) begin : g_bad_last
         $error("picc_cmd_decode: LAST_PAGE does not fit ADDR_W");
      end
   endgenerate

   logic cw_kind_is_write;

   generate
      if (ALLOW_CWRITE) begin : g_cw_on
         assign cw_kind_is_write = 1'b1;
      end else begin : g_cw_off
         assign cw_kind_is_write = 1'b0;
      end
   endgenerate

   always_comb begin
      case (cmd)
         OP_REQ:    kind = K_REQ;
         OP_WAKE:   kind = K_WAKE;
         OP_CL1:    kind = K_CL1;
         OP_CL2:    kind = K_CL2;
         OP_READ:   kind = K_READ;
         OP_WRITE:  kind = K_WRITE;
         OP_CWRITE: kind = cw_kind_is_write ? K_WRITE : K_BAD;
         OP_HALT:   kind = K_HALT;
         OP_AU1:    kind = K_AU1;
         OP_AU2:    kind = K_AU2;
         default:   kind = K_BAD;
      endcase
   end

   assign sel       = (param == SEL_CODE);
   assign addr_ok   = (addr <= LAST_A);
   assign addr_zero = (addr == '0);

endmodule

// File: rtl/picc_uid_parts.sv
module picc_uid_parts #(
   parameter int         UID_BYTES = 7,
   parameter logic [7:0] CT_BYTE   = 8'h88
) (
   input  logic [8*UID_BYTES-1:0] uid,
   output logic [39:0]            part1,
   output logic [39:0]            part2
);

   localparam int HALF1 = 3;
   localparam int HALF2 = UID_BYTES - HALF1;

   generate
      if (UID_BYTES != 7) begin : g_bad_len
         $error("picc_uid_parts: a two-level cascade needs a 7-byte UID");
      end
   endgenerate

   logic [7:0] sn [UID_BYTES];

   generate
      for (genvar gi = 0; gi < UID_BYTES; gi++) begin : g_split
         assign sn[gi] = uid[8*gi +: 8];
      end
   endgenerate

   logic [7:0] bcc_lo, bcc_hi;

   always_comb begin
      bcc_lo = CT_BYTE;
      for (int i = 0; i < HALF1; i++) bcc_lo = bcc_lo ^ sn[i];
      bcc_hi = 8'h00;
      for (int i = 0; i < HALF2; i++) bcc_hi = bcc_hi ^ sn[HALF1 + i];
   end

   assign part1 = {bcc_lo, sn[2], sn[1], sn[0], CT_BYTE};
   assign part2 = {bcc_hi, sn[6], sn[5], sn[4], sn[3]};

endmodule

// File: rtl/picc_state_core.sv
module picc_state_core
   import picc_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      valid,
   input  cmd_kind_e kind,
   input  logic      sel,
   input  logic      addr_ok,
   input  logic      addr_zero,
   input  logic      auth_ok,
   output card_st_e  st_q,
   output rsp_kind_e rk_q,
   output logic      lvl_q,
   output logic      rd_q,
   output logic      wr_q,
   output logic      au_q
);

   card_st_e  st_n;
   rsp_kind_e rk_n;
   logic      halted_q, halted_n;
   logic      p1_q, p1_n, p2_q, p2_n;
   logic      lvl_n, rd_n, wr_n, au_n;
   logic      in_mem;
   card_st_e  err_st;

   assign in_mem = (st_q == ST_ACT) || (st_q == ST_AUTH);
   assign err_st = halted_q ? ST_HALT : ST_IDLE;

   always_comb begin
      st_n     = st_q;
      halted_n = halted_q;
      p1_n     = p1_q;
      p2_n     = p2_q;
      rk_n     = RK_NONE;
      lvl_n    = 1'b0;
      rd_n     = 1'b0;
      wr_n     = 1'b0;
      au_n     = 1'b0;
      if (valid) begin
         p1_n = 1'b0;
         p2_n = 1'b0;
         case (kind)
            K_REQ: begin
               if (st_q == ST_IDLE) begin
                  rk_n = RK_ATQA;
                  st_n = ST_RDY1;
               end else st_n = err_st;
            end
            K_WAKE: begin
               if (st_q == ST_IDLE || st_q == ST_HALT) begin
                  rk_n = RK_ATQA;
                  st_n = ST_RDY1;
               end else st_n = err_st;
            end
            K_CL1: begin
               if (st_q == ST_RDY1) begin
                  rk_n = RK_UID;
                  if (sel) st_n = ST_RDY2;
               end else st_n = err_st;
            end
            K_CL2: begin
               if (st_q == ST_RDY2) begin
                  rk_n  = RK_UID;
                  lvl_n = 1'b1;
                  if (sel) st_n = ST_ACT;
               end else st_n = err_st;
            end
            K_READ: begin
               if (st_q == ST_RDY1 || st_q == ST_RDY2) begin
                  if (addr_zero) begin
                     rd_n = 1'b1;
                     st_n = ST_ACT;
                  end else st_n = err_st;
               end else if (in_mem) begin
                  if (addr_ok) rd_n = 1'b1;
                  else         rk_n = RK_NAK;
               end else st_n = err_st;
            end
            K_WRITE: begin
               if (in_mem) begin
                  if (addr_ok) wr_n = 1'b1;
                  else         rk_n = RK_NAK;
               end else st_n = err_st;
            end
            K_HALT: begin
               if (st_q == ST_RDY1 || st_q == ST_RDY2 || in_mem) begin
                  st_n     = ST_HALT;
                  halted_n = 1'b1;
               end else st_n = err_st;
            end
            K_AU1: begin
               if (in_mem) begin
                  au_n = 1'b1;
                  p1_n = 1'b1;
               end else st_n = err_st;
            end
            K_AU2: begin
               if (in_mem && p1_q) begin
                  au_n = 1'b1;
                  p2_n = 1'b1;
               end else st_n = err_st;
            end
            default: st_n = err_st;
         endcase
      end else if (auth_ok && p2_q && in_mem) begin
         st_n = ST_AUTH;
         p2_n = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         halted_q <= 1'b0;
         p1_q     <= 1'b0;
         p2_q     <= 1'b0;
         rk_q     <= RK_NONE;
         lvl_q    <= 1'b0;
         rd_q     <= 1'b0;
         wr_q     <= 1'b0;
         au_q     <= 1'b0;
      end else begin
         st_q     <= st_n;
         halted_q <= halted_n;
         p1_q     <= p1_n;
         p2_q     <= p2_n;
         rk_q     <= rk_n;
         lvl_q    <= lvl_n;
         rd_q     <= rd_n;
         wr_q     <= wr_n;
         au_q     <= au_n;
      end
   end

   AST_RDY2_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_RDY2 && $past(st_q) != ST_RDY2) |-> $past(st_q) == ST_RDY1); // R3

   AST_ACT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_ACT && $past(st_q) != ST_ACT) |->
      ($past(st_q) == ST_RDY1 || $past(st_q) == ST_RDY2)); // R5

   AST_AUTH_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_AUTH && $past(st_q) != ST_AUTH) |-> $past(st_q) == ST_ACT); // R9

   AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      halted_q |=> halted_q); // R7

   AST_NO_IDLE_AFTER_HALT: assert property (@(posedge clk) disable iff (!rst_n)
      halted_q |-> st_q != ST_IDLE); // R8

endmodule

// File: rtl/picc_cmd_ctrl.sv
module picc_cmd_ctrl
   import picc_pkg::*;
#(
   parameter int          ADDR_W       = 8,
   parameter int          LAST_PAGE    = 8'h2B,
   parameter int          UID_BYTES    = 7,
   parameter logic [15:0] ATQA_VAL     = 16'h0044,
   parameter logic [7:0]  CT_BYTE      = 8'h88,
   parameter logic [7:0]  SEL_CODE     = 8'h70,
   parameter bit          ALLOW_CWRITE = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   frm_valid,
   input  logic [7:0]             frm_cmd,
   input  logic [7:0]             frm_param,
   input  logic [ADDR_W-1:0]      frm_addr,
   input  logic                   auth_ok,
   input  logic [8*UID_BYTES-1:0] uid_in,
   output logic                   rsp_valid,
   output logic [1:0]             rsp_kind,
   output logic [2:0]             rsp_len,
   output logic [39:0]            rsp_data,
   output logic                   mem_rd_stb,
   output logic                   mem_wr_stb,
   output logic [ADDR_W-1:0]      mem_addr,
   output logic                   auth_stb,
   output logic [2:0]             card_state
);

   localparam int RSP_W = 8 * RSP_BYTES;

   cmd_kind_e   kind;
   logic        sel, addr_ok, addr_zero;
   card_st_e    st;
   rsp_kind_e   rk;
   logic        lvl;
   logic [39:0] part1, part2;
   logic [ADDR_W-1:0] addr_q;

   picc_cmd_decode #(
      .ADDR_W(ADDR_W), .LAST_PAGE(LAST_PAGE),
      .SEL_CODE(SEL_CODE), .ALLOW_CWRITE(ALLOW_CWRITE)
   ) u_dec (
      .cmd(frm_cmd), .param(frm_param), .addr(frm_addr),
      .kind(kind), .sel(sel), .addr_ok(addr_ok), .addr_zero(addr_zero)
   );

   picc_uid_parts #(.UID_BYTES(UID_BYTES), .CT_BYTE(CT_BYTE)) u_uid (
      .uid(uid_in), .part1(part1), .part2(part2)
   );

   picc_state_core u_core (
      .clk(clk), .rst_n(rst_n), .valid(frm_valid), .kind(kind), .sel(sel),
      .addr_ok(addr_ok), .addr_zero(addr_zero), .auth_ok(auth_ok),
      .st_q(st), .rk_q(rk), .lvl_q(lvl),
      .rd_q(mem_rd_stb), .wr_q(mem_wr_stb), .au_q(auth_stb)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         addr_q <= '0;
      else if (frm_valid) addr_q <= frm_addr;
   end

   always_comb begin
      case (rk)
         RK_ATQA: begin
            rsp_len  = 3'd2;
            rsp_data = {{(RSP_W-16){1'b0}}, ATQA_VAL};
         end
         RK_UID: begin
            rsp_len  = 3'(RSP_BYTES);
            rsp_data = lvl ? part2 : part1;
         end
         RK_NAK: begin
            rsp_len  = 3'd1;
            rsp_data = '0;
         end
         default: begin
            rsp_len  = 3'd0;
            rsp_data = '0;
         end
      endcase
   end

   assign rsp_valid  = (rk != RK_NONE);
   assign rsp_kind   = rk;
   assign mem_addr   = addr_q;
   assign card_state = st;

   AST_UID_CHECKSUM: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_kind == 2'd2) |->
      ((rsp_data[7:0] ^ rsp_data[15:8] ^ rsp_data[23:16] ^
        rsp_data[31:24] ^ rsp_data[39:32]) == 8'h00)); // R4

   AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rsp_valid, mem_rd_stb, mem_wr_stb, auth_stb})); // R10

   AST_ACTION_AFTER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid || mem_rd_stb || mem_wr_stb || auth_stb) |-> $past(frm_valid)); // R10

   AST_WRITE_STATE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_stb |-> (card_state == 3'd3 || card_state == 3'd4)); // R6

endmodule

// File: tb/picc_cmd_ctrl_tb.sv
module picc_cmd_ctrl_tb;

   localparam logic [7:0] LAST = 8'h2B;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        frm_valid = 1'b0;
   logic [7:0]  frm_cmd = '0, frm_param = '0, frm_addr = '0;
   logic        auth_ok = 1'b0;
   logic [55:0] uid_in = 56'h6655443322A104;

   logic        rsp_valid, mem_rd_stb, mem_wr_stb, auth_stb;
   logic [1:0]  rsp_kind;
   logic [2:0]  rsp_len, card_state;
   logic [39:0] rsp_data;
   logic [7:0]  mem_addr;

   logic        n_rsp_valid, n_rd, n_wr, n_au;
   logic [1:0]  n_kind;
   logic [2:0]  n_len, n_state;
   logic [39:0] n_data;
   logic [7:0]  n_addr;

   int total = 0;
   int bad   = 0;

   always #5 clk = ~clk;

   picc_cmd_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_cmd(frm_cmd),
      .frm_param(frm_param), .frm_addr(frm_addr), .auth_ok(auth_ok), .uid_in(uid_in),
      .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_len(rsp_len), .rsp_data(rsp_data),
      .mem_rd_stb(mem_rd_stb), .mem_wr_stb(mem_wr_stb), .mem_addr(mem_addr),
      .auth_stb(auth_stb), .card_state(card_state)
   );

   picc_cmd_ctrl #(.ALLOW_CWRITE(1'b0)) u_dut_ncw (
      .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_cmd(frm_cmd),
      .frm_param(frm_param), .frm_addr(frm_addr), .auth_ok(auth_ok), .uid_in(uid_in),
      .rsp_valid(n_rsp_valid), .rsp_kind(n_kind), .rsp_len(n_len), .rsp_data(n_data),
      .mem_rd_stb(n_rd), .mem_wr_stb(n_wr), .mem_addr(n_addr),
      .auth_stb(n_au), .card_state(n_state)
   );

   // reference model state
   logic [2:0] m_st;
   logic       m_h, m_p1, m_p2;
   logic [1:0] e_kind;
   logic       e_lvl, e_rd, e_wr, e_au;

   initial begin
      repeat (200000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: run did not finish (actual=hung expected=done)");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   function automatic logic [39:0] exp_data(input logic [1:0] k, input logic lvl, input logic [55:0] u);
      logic [7:0] s [7];
      for (int i = 0; i < 7; i++) s[i] = u[8*i +: 8];
      case (k)
         2'd1: return 40'h0000000044;
         2'd2: if (!lvl) return {8'h88 ^ s[0] ^ s[1] ^ s[2], s[2], s[1], s[0], 8'h88};
               else      return {s[3] ^ s[4] ^ s[5] ^ s[6], s[6], s[5], s[4], s[3]};
         default: return 40'h0;
      endcase
   endfunction

   task automatic model(input logic [7:0] c, input logic [7:0] p, input logic [7:0] a);
      logic [2:0] err;
      logic mem;
      err = m_h ? 3'd5 : 3'd0;
      mem = (m_st == 3'd3) || (m_st == 3'd4);
      e_kind = 2'd0; e_lvl = 1'b0; e_rd = 1'b0; e_wr = 1'b0; e_au = 1'b0;
      begin
         logic p1_was;
         p1_was = m_p1;
         m_p1 = 1'b0;
         m_p2 = 1'b0;
         if (c == 8'h26) begin
            if (m_st == 3'd0) begin e_kind = 2'd1; m_st = 3'd1; end else m_st = err;
         end else if (c == 8'h52) begin
            if (m_st == 3'd0 || m_st == 3'd5) begin e_kind = 2'd1; m_st = 3'd1; end else m_st = err;
         end else if (c == 8'h93) begin
            if (m_st == 3'd1) begin e_kind = 2'd2; if (p == 8'h70) m_st = 3'd2; end else m_st = err;
         end else if (c == 8'h95) begin
            if (m_st == 3'd2) begin e_kind = 2'd2; e_lvl = 1'b1; if (p == 8'h70) m_st = 3'd3; end
            else m_st = err;
         end else if (c == 8'h30) begin
            if (m_st == 3'd1 || m_st == 3'd2) begin
               if (a == 8'h00) begin e_rd = 1'b1; m_st = 3'd3; end else m_st = err;
            end else if (mem) begin
               if (a <= LAST) e_rd = 1'b1; else e_kind = 2'd3;
            end else m_st = err;
         end else if (c == 8'hA2 || c == 8'hA0) begin
            if (mem) begin if (a <= LAST) e_wr = 1'b1; else e_kind = 2'd3; end else m_st = err;
         end else if (c == 8'h50) begin
            if (m_st >= 3'd1 && m_st <= 3'd4) begin m_st = 3'd5; m_h = 1'b1; end else m_st = err;
         end else if (c == 8'h1A) begin
            if (mem) begin e_au = 1'b1; m_p1 = 1'b1; end else m_st = err;
         end else if (c == 8'hAF) begin
            if (mem && p1_was) begin e_au = 1'b1; m_p2 = 1'b1; end else m_st = err;
         end else m_st = err;
      end
   endtask

   task automatic compare(input string tag, input logic [7:0] a);
      chk(tag, "card_state", 64'(card_state), 64'(m_st));
      chk(tag, "rsp_valid",  64'(rsp_valid),  64'(e_kind != 2'd0));
      chk(tag, "rsp_kind",   64'(rsp_kind),   64'(e_kind));
      chk(tag, "rsp_len",    64'(rsp_len),
          64'(e_kind == 2'd1 ? 3'd2 : e_kind == 2'd2 ? 3'd5 : e_kind == 2'd3 ? 3'd1 : 3'd0));
      chk(tag, "rsp_data",   64'(rsp_data),   64'(exp_data(e_kind, e_lvl, uid_in)));
      chk(tag, "strobes", 64'({mem_rd_stb, mem_wr_stb, auth_stb}), 64'({e_rd, e_wr, e_au}));
      if (e_rd || e_wr) chk(tag, "mem_addr", 64'(mem_addr), 64'(a));
   endtask

   task automatic send(input logic [7:0] c, input logic [7:0] p, input logic [7:0] a, input string tag);
      @(negedge clk);
      frm_valid = 1'b1; frm_cmd = c; frm_param = p; frm_addr = a;
      @(negedge clk);
      frm_valid = 1'b0;
      model(c, p, a);
      compare(tag, a);
   endtask

   task automatic pulse_auth(input string tag);
      @(negedge clk);
      auth_ok = 1'b1;
      @(negedge clk);
      auth_ok = 1'b0;
      if (m_p2 && (m_st == 3'd3 || m_st == 3'd4)) begin m_st = 3'd4; m_p2 = 1'b0; end
      chk(tag, "state after auth_ok", 64'(card_state), 64'(m_st));
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      m_st = 3'd0; m_h = 1'b0; m_p1 = 1'b0; m_p2 = 1'b0;
   endtask

   task automatic setup(input int s);
      do_reset();
      if (s >= 1) send(8'h26, 8'h00, 8'h00, "R2");
      if (s >= 2 && s != 1) send(8'h93, 8'h70, 8'h00, "R3");
      if (s >= 3) send(8'h95, 8'h70, 8'h00, "R3");
      if (s == 4) begin
         send(8'h1A, 8'h00, 8'h00, "R9");
         send(8'hAF, 8'h00, 8'h00, "R9");
         pulse_auth("R9");
      end
      if (s >= 5) send(8'h50, 8'h00, 8'h00, "R7");
      if (s == 6) send(8'h52, 8'h00, 8'h00, "R2");
   endtask

   function automatic string tag_of(input logic [7:0] c);
      case (c)
         8'h26, 8'h52: return "R2";
         8'h93, 8'h95: return "R3";
         8'h30:        return "R5";
         8'hA2, 8'hA0: return "R6";
         8'h50:        return "R7";
         8'h1A, 8'hAF: return "R9";
         default:      return "R8";
      endcase
   endfunction

   initial begin
      m_st = 3'd0; m_h = 1'b0; m_p1 = 1'b0; m_p2 = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk("R1", "card_state", 64'(card_state), 64'd0);
      chk("R1", "outputs", 64'({rsp_valid, mem_rd_stb, mem_wr_stb, auth_stb}), 64'd0);

      // R4: cascade bytes with a second serial number
      uid_in = 56'hF0E1D2C3B4A504;
      setup(1);
      send(8'h93, 8'h20, 8'h00, "R4");
      chk("R4", "level1 bytes", 64'(rsp_data), 64'({8'h88 ^ 8'h04 ^ 8'hA5 ^ 8'hB4, 8'hB4, 8'hA5, 8'h04, 8'h88}));
      send(8'h93, 8'h70, 8'h00, "R4");
      send(8'h95, 8'h70, 8'h00, "R4");
      chk("R4", "level2 bytes", 64'(rsp_data), 64'({8'hC3 ^ 8'hD2 ^ 8'hE1 ^ 8'hF0, 8'hF0, 8'hE1, 8'hD2, 8'hC3}));
      uid_in = 56'h6655443322A104;

      // R10: strobes last one cycle only
      send(8'h30, 8'h00, 8'h2B, "R6");
      @(negedge clk);
      chk("R10", "strobes gone", 64'({rsp_valid, mem_rd_stb, mem_wr_stb, auth_stb}), 64'd0);

      // R9: auth_ok ignored without step two, and after an intervening frame
      pulse_auth("R9");
      chk("R9", "no auth without steps", 64'(card_state), 64'd3);
      send(8'h1A, 8'h00, 8'h00, "R9");
      send(8'hAF, 8'h00, 8'h00, "R9");
      send(8'h30, 8'h00, 8'h04, "R9");
      pulse_auth("R9");
      chk("R9", "frame between", 64'(card_state), 64'd3);

      // R11: compatibility write disabled in the second instance
      setup(3);
      send(8'hA0, 8'h00, 8'h05, "R11");
      chk("R11", "cw on grants", 64'(mem_wr_stb), 64'd1);
      chk("R11", "cw off state", 64'(n_state), 64'd0);
      chk("R11", "cw off silent", 64'({n_rsp_valid, n_wr}), 64'd0);

      // R8: error after halt returns to halt
      setup(6);
      send(8'h77, 8'h00, 8'h00, "R8");
      chk("R8", "back to halt", 64'(card_state), 64'd5);

      // sweep of every code from every state
      for (int s = 0; s < 7; s++) begin
         for (int c = 0; c < 256; c++) begin
            for (int v = 0; v < 3; v++) begin
               setup(s);
               send(8'(c), (v == 0) ? 8'h70 : 8'h20,
                    (v == 0) ? 8'h00 : (v == 1) ? 8'h05 : LAST + 8'd1, tag_of(8'(c)));
            end
         end
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule